// File: doc/BRIEF.md
# Segmented Ramp Video Source

This block produces a synthetic video frame on an AXI4-Stream master port. It is meant to drive a camera-serial transmit controller during bring-up and test. Each frame has `ROWS` lines, three by default. Every line is cut into three packets of unequal length, and each packet ends with `tlast`. The pixel bytes form a horizontal ramp that restarts at zero at the start of every line.

A one-cycle `start` pulse launches exactly one frame. The block then waits until it has seen `tready` high before it shows its first beat, because the downstream controller may keep `tready` low for a long time after its own reset. The first beat of the frame carries a frame-start flag on `tuser`, which the downstream needs before it will send high-speed data. The block honours backpressure on every beat. When the final beat of the frame has been accepted, `done` pulses for one cycle.

Top module: `seg_ramp_gen`

## Requirements
- R1: After reset, `m_tvalid`, `m_tlast`, `m_tuser` and `done` are low.
- R2: After `start`, `m_tvalid` stays low until `m_tready` has been sampled high on a clock edge. The first beat then appears in the cycle that follows that edge.
- R3: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tlast` and `m_tuser` hold their values into the next cycle.
- R4: `m_tuser` is high on the first beat of each frame and low on every other beat.
- R5: Each line is sent as three packets, in the order 8, 16 and 177 beats (32, 64 and 708 bytes at 4 bytes per beat). `m_tlast` is high only on the final beat of each packet.
- R6: Byte lane i, held in bits [8i+7:8i], carries (p + i) mod 256, where p is the byte offset of the beat within its line. p is 0 on the first beat of every line.
- R7: A frame contains exactly `ROWS` lines, which is three by default, so it carries 3*`ROWS` `tlast` pulses.
- R8: `done` is high for exactly one cycle: the cycle after the final beat of the frame is accepted. `m_tvalid` is low in that cycle.
- R9: A `start` pulse that arrives while a frame is in progress has no effect. No extra frame follows.
- R10: A `start` after `done` launches a complete new frame that again begins with `m_tuser` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one frame when the block is idle |
| m_tdata | output | DATA_W | Ramp pixel bytes, lane 0 in the low byte |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Final beat of a packet |
| m_tuser | output | 1 | Frame-start flag |
| done | output | 1 | One-cycle pulse when the frame is finished |

## Verification
The assertions assume that `m_tready` is a registered, glitch-free level that the downstream may drop or raise in any cycle. They also assume that `start` is a single-cycle pulse. The bench drives `m_tready` and `start` only on the falling edge, so both are stable at every rising edge. It applies a constantly ready pattern, a periodic stall and a pseudo-random stall. It also holds `m_tready` low for a long stretch after `start`.

// File: rtl/seg_ramp_gen.sv
module seg_ramp_gen #(
  parameter int DATA_W     = 32,
  parameter int ROWS       = 3,
  parameter int SEG0_BYTES = 32,
  parameter int SEG1_BYTES = 64,
  parameter int SEG2_BYTES = 708
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  output logic              m_tuser,
  output logic              done
);
  localparam int BPB   = DATA_W / 8;
  localparam int S0    = SEG0_BYTES / BPB;
  localparam int S1    = SEG1_BYTES / BPB;
  localparam int S2    = SEG2_BYTES / BPB;
  localparam int SMAX  = (S0 > S1) ? ((S0 > S2) ? S0 : S2) : ((S1 > S2) ? S1 : S2);
  localparam int BW    = $clog2(SMAX + 1);
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;

  typedef enum logic [1:0] {IDLE, ARM, SEND} state_t;

  state_t        state;
  logic [RW-1:0] row;
  logic [1:0]    seg;
  logic [BW-1:0] beat, seg_len;
  logic [7:0]    off;
  logic          done_q;

  always_comb
    case (seg)
      2'd0:    seg_len = BW'(S0);
      2'd1:    seg_len = BW'(S1);
      default: seg_len = BW'(S2);
    endcase

  wire seg_end  = beat == seg_len - BW'(1);
  wire line_end = seg_end && seg == 2'd2;
  wire frm_end  = line_end && row == RW'(ROWS - 1);
  wire take     = state == SEND && m_tready;

  assign m_tvalid = state == SEND;
  assign m_tlast  = m_tvalid && seg_end;
  assign m_tuser  = m_tvalid && row == '0 && seg == 2'd0 && beat == '0;
  assign done     = done_q;

  for (genvar g = 0; g < BPB; g++) begin : g_lane
    assign m_tdata[8*g +: 8] = off + 8'(g);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      row    <= '0;
      seg    <= '0;
      beat   <= '0;
      off    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        IDLE: if (start) begin
          state <= ARM;
          row   <= '0;
          seg   <= '0;
          beat  <= '0;
          off   <= '0;
        end
        ARM: if (m_tready) state <= SEND;
        default: if (take) begin
          off  <= off + 8'(BPB);
          beat <= beat + BW'(1);
          if (seg_end) begin
            beat <= '0;
            seg  <= seg + 2'd1;
          end
          if (line_end) begin
            seg <= '0;
            off <= '0;
            row <= row + RW'(1);
          end
          if (frm_end) begin
            state  <= IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module seg_ramp_gen_chk #(parameter int DATA_W = 32) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              m_tlast,
  input logic              m_tuser,
  input logic              done
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser)); // R3
  AST_READY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_tvalid) |-> $past(m_tready)); // R2
  AST_FIRST_USER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_tvalid) |-> m_tuser); // R4
  AST_USER_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    m_tuser && m_tready |=> !m_tuser); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_tvalid && $past(m_tvalid && m_tready && m_tlast)); // R8
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_tdata[15:8] == m_tdata[7:0] + 8'd1); // R6
endmodule

bind seg_ramp_gen seg_ramp_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
  .m_tready(m_tready), .m_tlast(m_tlast), .m_tuser(m_tuser), .done(done));

// File: tb/seg_ramp_gen_test.sv
module seg_ramp_gen_test;
  logic        clk = 0, rst_n = 0, start = 0, tready = 0;
  logic [31:0] tdata;
  logic        tvalid, tlast, tuser, done;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  seg_ramp_gen uut (.clk(clk), .rst_n(rst_n), .start(start), .m_tdata(tdata),
    .m_tvalid(tvalid), .m_tready(tready), .m_tlast(tlast), .m_tuser(tuser), .done(done));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(tvalid == 0, "R1", "tvalid", tvalid, 0);
    chk(tlast == 0 && tuser == 0, "R1", "tlast/tuser", {tlast, tuser}, 0);
    chk(done == 0, "R1", "done", done, 0);
  endtask

  // mode 0: always ready, 1: periodic stall, 2: pseudo-random stall
  task automatic run_frame(int mode, bit launch, bit poke);
    int lens[3] = '{8, 16, 177};
    int r = 0, s = 0, b = 0, cyc = 0, tl = 0;
    logic [7:0] off = 0, lf = 8'hA5;
    bit fin = 0, stalled = 0;
    logic [31:0] hd;
    logic hl, hu;
    logic [31:0] ed;
    if (launch) begin
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!fin) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 0) : (lf[0] | lf[1]);
      start = poke && (cyc == 50 || cyc == 300);
      cyc++;
      if (stalled)
        chk(tvalid && tdata == hd && tlast == hl && tuser == hu, "R3", "hold under stall",
            {tvalid, tdata}, {1'b1, hd});
      if (tvalid) begin
        for (int i = 0; i < 4; i++) ed[8*i +: 8] = off + 8'(i);
        chk(tdata == ed, "R6", "ramp data", tdata, ed);
        chk(tuser == (r == 0 && s == 0 && b == 0), "R4", "tuser", tuser, (r == 0 && s == 0 && b == 0));
        chk(tlast == (b == lens[s] - 1), "R5", "tlast", tlast, (b == lens[s] - 1));
        if (tready) begin
          stalled = 0;
          off += 8'd4;
          b++;
          if (b == lens[s]) begin
            tl++; b = 0; s++;
            if (s == 3) begin
              s = 0; off = 0; r++;
              if (r == 3) fin = 1;
            end
          end
        end else begin
          stalled = 1; hd = tdata; hl = tlast; hu = tuser;
        end
      end
      @(negedge clk);
    end
    start = 0;
    chk(tl == 9, "R7", "tlast pulses per frame", tl, 9);
    chk(done == 1, "R8", "done after final beat", done, 1);
    chk(tvalid == 0, "R8", "tvalid with done", tvalid, 0);
    @(negedge clk);
    chk(done == 0, "R8", "done one cycle", done, 0);
    for (int k = 0; k < 20; k++) begin
      chk(tvalid == 0, "R9", "no extra frame", tvalid, 0);
      @(negedge clk);
    end
  endtask

  task automatic test_wait_ready();
    tready = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 40; k++) begin
      chk(tvalid == 0, "R2", "valid before ready seen", tvalid, 0);
      @(negedge clk);
    end
    tready = 1;
    @(negedge clk);
    chk(tvalid == 1, "R2", "first beat after ready", tvalid, 1);
    chk(tuser == 1 && tdata == 32'h03020100, "R4", "first beat content", {tuser, tdata}, {1'b1, 32'h03020100});
    run_frame(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_wait_ready();
    run_frame(1, 1, 1);
    run_frame(2, 1, 0);
    run_frame(0, 1, 0); // R10 new frame after done
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule